// File: doc/BRIEF.md
# Pseudo-SRAM Configuration Register Loader

This block programs, and optionally reads back, the configuration register of an asynchronous pseudo-SRAM. It works on behalf of a host that supplies a 20-bit configuration word, picks one of two access methods and pulses `start`. Before it touches the memory pins it asks the normal access controller for the bus through a request/grant pair. It hands the pins back when the sequence ends.

The sleep-pin method is write only. The loader pulls the sleep pin low and places the configuration word on the address bus. After a short lead time it drops chip enable and write enable together. The word is latched on the rising strobe edge. The software method uses four ordinary bus cycles, all to the all-ones address: two reads, then a write of 0000h, then either a write of the value on the data bus or a read that returns the register contents.

Before any bus activity the loader checks the refresh-temperature field of a write request. The field is configuration bits 6:5: 00 selects +85 °C, 01 +70 °C, 10 +45 °C and 11 +15 °C. It also clears the reserved bits of the word. If the grant is withdrawn part way through a sequence, the whole sequence starts again from its first cycle.

Top module: `psram_cfg_loader`

## Requirements
- R1: After reset all strobes (`memCeN`, `memWeN`, `memOeN`, `memZzN`, both `memBeN` bits) are high, `memDqOe`, `busReq`, `done` and `err` are low, and `memAddr` is 0.
- R2: An accepted `start` raises `busReq`. Until `busGnt` is high, no strobe goes low and the sleep pin stays high.
- R3: Sleep-pin method: `memZzN` is low for exactly `ZZ_LEAD_CYC` cycles before one strobe with `memCeN` and `memWeN` low together. During the strobe the address carries the configuration word, `memOeN` is high, `memDqOe` is low and `memBeN` is 2'b11.
- R4: Software method: four strobes, all at address 20'hFFFFF, in this order: read, read, write with data 16'h0000, then a write of the configuration word's low 16 bits (`readBack`=0) or a read (`readBack`=1). Read strobes have `memOeN` low and `memDqOe` low. Write strobes have `memWeN` low and `memDqOe` high.
- R5: In a software read, `rdData` holds the `memDqIn` value present during the fourth strobe.
- R6: Configuration bits 19:8 and bit 3 are forced to 0 in whatever goes to the memory: the address in the sleep-pin method, the data in the software method. Bits 7:4 and 2:0 pass unchanged.
- R7: A write request whose band field (bits 6:5) is numerically above `MAX_BAND` is refused. `err` is high for one cycle, in the cycle after `start`, and there is no `busReq`, no strobe and no `done`. A software read is never refused.
- R8: If `busGnt` falls during a sequence, the pins return to idle in the next cycle. Once the grant returns, the sequence restarts from its first cycle.
- R9: `done` is a one-cycle pulse. It comes exactly `RECOV_CYC` cycles after the rising edge of the last strobe.
- R10: Each strobe holds `memCeN` low for exactly `STROBE_CYC` cycles with a stable address. `memWeN` and `memOeN` are never low together, and data is never driven while `memOeN` is low.
- R11: A `start` pulse that arrives while a sequence is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a sequence |
| useSleepPin | input | 1 | 1 = sleep-pin method, 0 = software method |
| readBack | input | 1 | Software method only: 1 = read the register, 0 = write it |
| cfgIn | input | 20 | Configuration word, sampled with `start` |
| busReq | output | 1 | Request for the memory pins |
| busGnt | input | 1 | Grant of the memory pins |
| memAddr | output | 20 | Memory address bus |
| memDqOut | output | 16 | Write data toward the memory |
| memDqOe | output | 1 | Data bus output enable |
| memDqIn | input | 16 | Read data from the memory |
| memCeN | output | 1 | Chip enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memBeN | output | 2 | Byte enables, active low |
| memZzN | output | 1 | Sleep pin, active low |
| rdData | output | 16 | Register value read back by the software method |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | One-cycle refusal pulse for an out-of-range band |

## Verification
The main sequence is driven with four patterns: a sleep-pin write, a software write, a software read, and a word with every reserved bit set. Together they separate the two methods, the write and read endings of the software method, and correct masking from a plain copy of the word. Band values 00, 01, 10 and 11 are each used with writes and with a read. This confirms that refusal depends on both the band and the direction. Further runs hold the grant off, drop it after the second strobe, and repeat `start` mid-sequence. These show a delayed start, a full restart from the first read, and an ignored extra request.

// File: rtl/psram_cfg_pkg.sv
`timescale 1ns/1ps
package psram_cfg_pkg;

  // Control phases of one loader sequence
  typedef enum logic [2:0] {
    PH_IDLE, PH_REQ, PH_SETUP, PH_STROBE, PH_RECOV, PH_DONE
  } phase_t;

  // Strobes from control to datapath, registered onto the pins
  typedef struct packed {
    logic busOwn;
    logic strobe;
    logic isWrite;
    logic driveDq;
    logic zzLow;
    logic useCfgAddr;
    logic useCfgData;
    logic capture;
    logic latchCfg;
    logic doneStb;
    logic errStb;
  } ctl_strb_t;

  // Band field location inside the configuration word
  localparam int BAND_LSB = 5;
  localparam int BAND_W   = 2;
  // Bits kept from the host word: 7:4 and 2:0; all others are reserved
  localparam logic [7:0] KEEP_LOW = 8'hF7;
  // Index of the last software-method cycle
  localparam logic [1:0] LAST_SW_STEP = 2'd3;
  localparam logic [1:0] SEL_SW_STEP  = 2'd2;

endpackage

// File: rtl/psram_cfg_ctrl.sv
`timescale 1ns/1ps
module psram_cfg_ctrl
  import psram_cfg_pkg::*;
#(
  parameter int SETUP_CYC   = 2,
  parameter int STROBE_CYC  = 3,
  parameter int RECOV_CYC   = 2,
  parameter int ZZ_LEAD_CYC = 4,
  parameter int MAX_BAND    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              useSleepPin,
  input  logic              readBack,
  input  logic [BAND_W-1:0] bandReq,
  output logic              busReq,
  input  logic              busGnt,
  output ctl_strb_t         strb
);

  localparam int MAX_AB  = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_CD  = (RECOV_CYC > ZZ_LEAD_CYC) ? RECOV_CYC : ZZ_LEAD_CYC;
  localparam int MAX_ALL = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = (MAX_ALL > 1) ? $clog2(MAX_ALL) : 1;

  localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] RECOV_LD  = CNT_W'(RECOV_CYC - 1);
  localparam logic [CNT_W-1:0] LEAD_LD   = CNT_W'(ZZ_LEAD_CYC - 1);

  phase_t           state;
  logic [1:0]       step;
  logic [CNT_W-1:0] cnt;
  logic             sleepM;
  logic             rdM;

  logic bandBad;
  logic inBus;
  logic owning;
  logic atLast;
  logic wrStep;
  logic cntZero;

  always_comb begin
    bandBad = (useSleepPin || !readBack) && (int'(bandReq) > MAX_BAND);
    inBus   = (state == PH_SETUP) || (state == PH_STROBE) || (state == PH_RECOV);
    owning  = inBus && busGnt;
    cntZero = (cnt == '0);
    atLast  = sleepM ? 1'b1 : (step == LAST_SW_STEP);
    wrStep  = sleepM || (step == SEL_SW_STEP) || ((step == LAST_SW_STEP) && !rdM);
    busReq  = (state == PH_REQ) || inBus;

    strb            = '0;
    strb.busOwn     = owning;
    strb.strobe     = owning && (state == PH_STROBE);
    strb.isWrite    = wrStep;
    strb.driveDq    = !sleepM && wrStep;
    strb.zzLow      = owning && sleepM;
    strb.useCfgAddr = sleepM;
    strb.useCfgData = (step == LAST_SW_STEP);
    // the pins still show the last strobe cycle during the first recovery cycle
    strb.capture    = owning && (state == PH_RECOV) && (cnt == RECOV_LD) &&
                      !sleepM && rdM && (step == LAST_SW_STEP);
    strb.latchCfg   = (state == PH_IDLE) && start && !bandBad;
    strb.errStb     = (state == PH_IDLE) && start && bandBad;
    strb.doneStb    = (state == PH_DONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= PH_IDLE;
      step   <= '0;
      cnt    <= '0;
      sleepM <= 1'b0;
      rdM    <= 1'b0;
    end else begin
      unique case (state)
        PH_IDLE: begin
          if (start && !bandBad) begin
            sleepM <= useSleepPin;
            rdM    <= readBack && !useSleepPin;
            step   <= '0;
            state  <= PH_REQ;
          end
        end
        PH_REQ: begin
          if (busGnt) begin
            step  <= '0;
            cnt   <= sleepM ? LEAD_LD : SETUP_LD;
            state <= PH_SETUP;
          end
        end
        PH_SETUP, PH_STROBE, PH_RECOV: begin
          if (!busGnt) begin
            step  <= '0;
            state <= PH_REQ;
          end else if (!cntZero) begin
            cnt <= cnt - 1'b1;
          end else if (state == PH_SETUP) begin
            cnt   <= STROBE_LD;
            state <= PH_STROBE;
          end else if (state == PH_STROBE) begin
            cnt   <= RECOV_LD;
            state <= PH_RECOV;
          end else if (atLast) begin
            state <= PH_DONE;
          end else begin
            step  <= step + 1'b1;
            cnt   <= SETUP_LD;
            state <= PH_SETUP;
          end
        end
        PH_DONE: state <= PH_IDLE;
        default: state <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/psram_cfg_path.sv
`timescale 1ns/1ps
module psram_cfg_path
  import psram_cfg_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strb_t         strb,
  input  logic [ADDR_W-1:0] cfgIn,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memBeN,
  output logic              memZzN,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              err
);

  localparam int LANES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] KEEP_MASK = ADDR_W'(KEEP_LOW);
  localparam logic [ADDR_W-1:0] TOP_ADDR  = '1;

  logic [ADDR_W-1:0] cfgReg;
  logic [ADDR_W-1:0] addrNext;
  logic [DATA_W-1:0] dataNext;
  logic [LANES-1:0]  laneNext;

  always_comb begin
    addrNext = strb.busOwn ? (strb.useCfgAddr ? cfgReg : TOP_ADDR) : '0;
    dataNext = (strb.busOwn && strb.driveDq && strb.useCfgData) ? cfgReg[DATA_W-1:0] : '0;
  end

  // one enable per byte lane; sleep-pin accesses leave the lanes deselected
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneNext[g] = !(strb.busOwn && !strb.zzLow);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg   <= '0;
      memAddr  <= '0;
      memDqOut <= '0;
      memDqOe  <= 1'b0;
      memCeN   <= 1'b1;
      memWeN   <= 1'b1;
      memOeN   <= 1'b1;
      memBeN   <= '1;
      memZzN   <= 1'b1;
      rdData   <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (strb.latchCfg) cfgReg <= cfgIn & KEEP_MASK;
      if (strb.capture)  rdData <= memDqIn;
      memAddr  <= addrNext;
      memDqOut <= dataNext;
      memDqOe  <= strb.busOwn && strb.driveDq;
      memCeN   <= !strb.strobe;
      memWeN   <= !(strb.strobe && strb.isWrite);
      memOeN   <= !(strb.strobe && !strb.isWrite);
      memBeN   <= laneNext;
      memZzN   <= !strb.zzLow;
      done     <= strb.doneStb;
      err      <= strb.errStb;
    end
  end

endmodule

// File: rtl/psram_cfg_loader.sv
`timescale 1ns/1ps
module psram_cfg_loader
  import psram_cfg_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int SETUP_CYC   = 2,
  parameter int STROBE_CYC  = 3,
  parameter int RECOV_CYC   = 2,
  parameter int ZZ_LEAD_CYC = 4,
  parameter int MAX_BAND    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              useSleepPin,
  input  logic              readBack,
  input  logic [ADDR_W-1:0] cfgIn,
  output logic              busReq,
  input  logic              busGnt,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W/8-1:0] memBeN,
  output logic              memZzN,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              err
);

  ctl_strb_t strb;

  psram_cfg_ctrl #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .RECOV_CYC  (RECOV_CYC),
    .ZZ_LEAD_CYC(ZZ_LEAD_CYC),
    .MAX_BAND   (MAX_BAND)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .useSleepPin(useSleepPin),
    .readBack   (readBack),
    .bandReq    (cfgIn[BAND_LSB +: BAND_W]),
    .busReq     (busReq),
    .busGnt     (busGnt),
    .strb       (strb)
  );

  psram_cfg_path #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cfgIn   (cfgIn),
    .memDqIn (memDqIn),
    .memAddr (memAddr),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe),
    .memCeN  (memCeN),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .memBeN  (memBeN),
    .memZzN  (memZzN),
    .rdData  (rdData),
    .done    (done),
    .err     (err)
  );

endmodule

// File: rtl/psram_cfg_loader_chk.sv
`timescale 1ns/1ps
module psram_cfg_loader_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busGnt,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memDqOe,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memZzN,
  input logic              done,
  input logic              err
);

  // R8
  strobe_granted_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memCeN |-> $past(busGnt));

  // R10
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!memWeN && !memOeN));

  // R10
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDqOe);

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (!busReq && memCeN && !done));

  // R3
  sleep_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memZzN |-> memOeN);

endmodule

bind psram_cfg_loader psram_cfg_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .busReq (busReq),
  .busGnt (busGnt),
  .memAddr(memAddr),
  .memDqOe(memDqOe),
  .memCeN (memCeN),
  .memWeN (memWeN),
  .memOeN (memOeN),
  .memZzN (memZzN),
  .done   (done),
  .err    (err)
);

// File: tb/sim_psram_cfg_loader.sv
`timescale 1ns/1ps
module sim_psram_cfg_loader;

  localparam int STROBE_CYC  = 3;
  localparam int RECOV_CYC   = 2;
  localparam int ZZ_LEAD_CYC = 4;
  localparam logic [19:0] KEEP = 20'h000F7;
  localparam logic [19:0] TOP  = 20'hFFFFF;

  typedef struct packed {
    logic [19:0] addr;
    logic        wr;
    logic        rd;
    logic        dqOe;
    logic [15:0] dq;
    logic        zz;
    logic [1:0]  be;
  } ev_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        useSleepPin = 1'b0;
  logic        readBack = 1'b0;
  logic [19:0] cfgIn = '0;
  logic        busReq;
  logic        busGnt;
  logic [19:0] memAddr;
  logic [15:0] memDqOut;
  logic        memDqOe;
  logic [15:0] memDqIn;
  logic        memCeN, memWeN, memOeN, memZzN;
  logic [1:0]  memBeN;
  logic [15:0] rdData;
  logic        done, err;

  logic        gntEn = 1'b1;
  logic        gntHold = 1'b0;
  logic [15:0] rdVal = 16'h0000;
  int          checks = 0;
  int          errors = 0;
  int          riseCount = 0;
  int          doneCount = 0;
  int          abortAt = -1;
  int          abortHold = 0;
  int          cycles = 0;

  ev_t expQ[$];

  assign busGnt  = busReq && gntEn && !gntHold;
  assign memDqIn = (!memCeN && !memOeN) ? rdVal : 16'hDEAD;

  always #2 clk = ~clk;

  psram_cfg_loader u0 (
    .clk(clk), .rstN(rstN), .start(start), .useSleepPin(useSleepPin),
    .readBack(readBack), .cfgIn(cfgIn), .busReq(busReq), .busGnt(busGnt),
    .memAddr(memAddr), .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN), .memBeN(memBeN),
    .memZzN(memZzN), .rdData(rdData), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- monitor: pops one expected item per strobe ----------------
  ev_t cur;
  bit  prevCe = 1'b1;
  int  lowCnt = 0;
  int  zzLead = 0;
  int  sinceRise = 1000;

  always @(negedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rstN) begin
      if (!memCeN) begin
        // R3: sleep pin lead time before the strobe falls
        if (prevCe && !memZzN) chk(zzLead == ZZ_LEAD_CYC, "R3 zz lead", zzLead, ZZ_LEAD_CYC);
        lowCnt++;
        cur = '{addr: memAddr, wr: !memWeN, rd: !memOeN, dqOe: memDqOe,
                dq: memDqOut, zz: !memZzN, be: memBeN};
      end
      if (memCeN && !prevCe) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R4 unexpected strobe", cur, 0);
        end else begin
          ev_t e;
          e = expQ.pop_front();
          chk(cur == e, "R4 strobe item", cur, e);
        end
        // R10: strobe width
        chk(lowCnt == STROBE_CYC, "R10 strobe width", lowCnt, STROBE_CYC);
        lowCnt = 0;
        riseCount++;
        sinceRise = 0;
      end else begin
        sinceRise++;
      end
      if (!memZzN && memCeN) zzLead++;
      else if (memZzN) zzLead = 0;
      if (done) begin
        // R9: done exactly RECOV_CYC after the last strobe rise
        chk(sinceRise == RECOV_CYC, "R9 done timing", sinceRise, RECOV_CYC);
        chk(expQ.size() == 0, "R4 all strobes seen", expQ.size(), 0);
        doneCount++;
      end
      // R8: grant withdrawal after a chosen strobe
      if (abortHold > 0) begin
        abortHold--;
        if (abortHold == 2)
          chk(memCeN && memAddr == 0 && memBeN == 2'b11, "R8 pins released",
              {memCeN, memBeN, memAddr}, {1'b1, 2'b11, 20'h0});
        if (abortHold == 0) gntEn = 1'b1;
      end else if (abortAt >= 0 && riseCount == abortAt) begin
        gntEn = 1'b0;
        abortHold = 3;
        abortAt = -1;
      end
      prevCe = memCeN;
    end
  end

  // ---------------- driver ----------------
  function automatic ev_t mkEv(logic [19:0] a, logic w, logic [15:0] d, logic z);
    ev_t e;
    e.addr = a; e.wr = w; e.rd = !w; e.dqOe = w && !z; e.dq = (w && !z) ? d : 16'h0;
    e.zz = z; e.be = z ? 2'b11 : 2'b00;
    return e;
  endfunction

  task automatic pushSeq(input bit sleep, input bit rd, input logic [19:0] cfg);
    if (sleep) begin
      expQ.push_back(mkEv(cfg & KEEP, 1'b1, 16'h0, 1'b1));
    end else begin
      expQ.push_back(mkEv(TOP, 1'b0, 16'h0, 1'b0));
      expQ.push_back(mkEv(TOP, 1'b0, 16'h0, 1'b0));
      expQ.push_back(mkEv(TOP, 1'b1, 16'h0000, 1'b0));
      expQ.push_back(mkEv(TOP, !rd, rd ? 16'h0 : cfg[15:0] & KEEP[15:0], 1'b0));
    end
  endtask

  task automatic pulseStart(input bit sleep, input bit rd, input logic [19:0] cfg);
    @(negedge clk);
    useSleepPin = sleep; readBack = rd; cfgIn = cfg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int d0;
    int t;
    d0 = doneCount;
    t = 0;
    while (doneCount == d0 && t < 500) begin
      @(negedge clk);
      t++;
    end
    chk(doneCount == d0 + 1, req, doneCount - d0, 1);
  endtask

  task automatic runOp(input bit sleep, input bit rd, input logic [19:0] cfg, input string req);
    pushSeq(sleep, rd, cfg);
    pulseStart(sleep, rd, cfg);
    waitDone(req);
  endtask

  task automatic refused(input bit sleep, input bit rd, input logic [19:0] cfg);
    int r0;
    int d0;
    r0 = riseCount;
    d0 = doneCount;
    pulseStart(sleep, rd, cfg);
    chk(err == 1'b1 && busReq == 1'b0, "R7 err raised", {err, busReq}, 2'b10);
    @(negedge clk);
    chk(err == 1'b0, "R7 err one cycle", err, 0);
    repeat (12) @(negedge clk);
    chk(riseCount == r0 && doneCount == d0 && !busReq, "R7 no activity",
        {riseCount - r0, doneCount - d0}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({memCeN, memWeN, memOeN, memZzN, memBeN, memDqOe, busReq, done, err} == 10'b1111110000 &&
        memAddr == 0, "R1 reset state",
        {memCeN, memWeN, memOeN, memZzN, memBeN, memDqOe, busReq, done, err}, 10'b1111110000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R3: sleep-pin write, band 00
    runOp(1'b1, 1'b0, 20'h00010, "R3 sleep write done");
    // R4: software write, band 01
    runOp(1'b0, 1'b0, 20'h000B4, "R4 software write done");
    // R5 / R7: software read, band 11 is not refused on a read
    rdVal = 16'h0091;
    runOp(1'b0, 1'b1, 20'h00060, "R7 read not refused");
    chk(rdData == 16'h0091, "R5 read back", rdData, 16'h0091);
    rdVal = 16'h5A3C;
    runOp(1'b0, 1'b1, 20'h00000, "R5 second read done");
    chk(rdData == 16'h5A3C, "R5 read back 2", rdData, 16'h5A3C);
    // R6: reserved bits cleared on both methods
    runOp(1'b0, 1'b0, 20'hFFFAF, "R6 software masked write");
    runOp(1'b1, 1'b0, 20'hFFFAF, "R6 sleep masked write");
    // R7: bands above the limit are refused for writes
    refused(1'b1, 1'b0, 20'h00040);
    refused(1'b0, 1'b0, 20'h00060);

    // R2: no pin activity before the grant
    gntHold = 1'b1;
    pushSeq(1'b0, 1'b0, 20'h00021);
    pulseStart(1'b0, 1'b0, 20'h00021);
    repeat (6) @(negedge clk);
    chk(busReq && memCeN && memZzN && memBeN == 2'b11, "R2 wait for grant",
        {busReq, memCeN, memZzN, memBeN}, 5'b11111);
    gntHold = 1'b0;
    waitDone("R2 completes after grant");

    // R8: grant lost after the second strobe, restart from the first read
    expQ.push_back(mkEv(TOP, 1'b0, 16'h0, 1'b0));
    expQ.push_back(mkEv(TOP, 1'b0, 16'h0, 1'b0));
    pushSeq(1'b0, 1'b0, 20'h00095);
    abortAt = riseCount + 2;
    pulseStart(1'b0, 1'b0, 20'h00095);
    waitDone("R8 restart completes");

    // R11: start while busy is ignored
    pushSeq(1'b1, 1'b0, 20'h00011);
    pulseStart(1'b1, 1'b0, 20'h00011);
    @(negedge clk);
    pulseStart(1'b0, 1'b1, 20'h00002);
    waitDone("R11 first op done");
    repeat (15) @(negedge clk);
    chk(!busReq && expQ.size() == 0, "R11 second start ignored", {busReq, expQ.size()}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule